// File: doc/BRIEF.md
# Per-Bank Refresh Sequencer

This block schedules per-bank refresh for a single DRAM rank inside a memory controller. A free-running cycle counter marks when the next per-bank refresh falls due. When that point arrives, the block takes the bank that is next in rotation and raises that bank's block line, so its request machine stops accepting new work. If the bank still holds an open row, the block asks for a precharge of that bank first. Otherwise it asks for the per-bank refresh at once.

Each command goes out only when an external timing checker reports that it is legal for that bank. The controller confirms the issue with an acknowledge. A refresh acknowledge moves the rotation to the next bank and releases the block line. It also moves the due point forward by exactly one refresh interval, measured from the previous due point. A late refresh therefore does not delay the schedule that follows it.

Top module: `bank_refresh_seq`

## Requirements
- R1: While reset is asserted, and while no refresh is pending, all block lines are low, `cmd_req` is low, `cmd_type` shows no-operation (code 0) and `cmd_bank` is 0.
- R2: The first refresh becomes pending, with the block line of bank 0 rising, right after the (REFI_CYCLES+1)-th rising edge that samples `rst_n` high.
- R3: When the target bank is closed at the due point, the pending command is a per-bank refresh (`cmd_type` code 2) for that bank.
- R4: When the target bank is open at the due point, the pending command is a precharge (`cmd_type` code 1) for that bank. After the precharge is acknowledged, the per-bank refresh for the same bank follows, and the rotation does not advance.
- R5: `cmd_req` is high only while a command is pending and `cmd_legal` is high. An acknowledge given while `cmd_req` is low has no effect.
- R6: Banks are refreshed in order 0, 1, …, NUM_BANKS-1, 0, …. The rotation advances by one only on an acknowledged per-bank refresh, and reset returns it to bank 0.
- R7: The k-th refresh (k from 0) is due REFI_CYCLES·(k+1) edges after reset, regardless of when earlier commands were issued, as long as each earlier refresh finished before that point.
- R8: While a refresh is pending, exactly one block line is high, the one for the target bank. It falls in the cycle after the refresh acknowledge.
- R9: If a refresh is acknowledged at or after the moment the next one fell due, the next bank's refresh becomes pending on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_open | input | NUM_BANKS | Per-bank flag: a row is open |
| cmd_legal | input | 1 | Timing checker: the shown command is legal on the shown bank now |
| cmd_ack | input | 1 | The requested command was issued this cycle |
| cmd_req | output | 1 | Command request, valid when a command is pending and legal |
| cmd_type | output | 2 | 0 no-operation, 1 precharge, 2 per-bank refresh |
| cmd_bank | output | $clog2(NUM_BANKS) | Target bank of the pending command, 0 when idle |
| bank_block | output | NUM_BANKS | Per-bank hold-off for the normal request machines |

## Verification
Two events can land on the same edge: the completion of one bank's refresh and the due point of the next one. The bench provokes this by holding `cmd_legal` low longer than a full refresh interval, so the next interval runs out while the current refresh is still waiting. It then checks that the block line of the finished bank falls, and that the next bank's block line rises on the following edge. It also checks that this next refresh is not delayed by a further interval, and that the one after it still falls on its nominal due point.

// File: rtl/brs_pkg.sv
// Shared encodings for the per-bank refresh sequencer.
package brs_pkg;

    // Command code seen by the command bus arbiter.
    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PRE  = 2'd1,
        CMD_REFB = 2'd2
    } brs_cmd_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_PRE  = 2'd1,
        ST_WAIT_REFB = 2'd2
    } brs_state_e;

endpackage

// File: rtl/brs_due_timer.sv
// Refresh due-point tracker.
// Counts controller cycles since the last due anchor. Raises `due` once a
// full interval has elapsed. On a completed refresh the anchor moves forward
// by exactly one interval, so backlog carries over instead of being lost.
// Assumes refb_done is only given while due is high. Saturates if refresh
// is starved for very long.
module brs_due_timer #(
    parameter int REFI_CYCLES = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refb_done,
    output logic due
);
    localparam int          CW     = $clog2(4 * REFI_CYCLES + 1);
    localparam logic [CW-1:0] REFI_W = CW'(REFI_CYCLES);
    localparam logic [CW-1:0] SAT_W  = '1;

    logic [CW-1:0] elapsed_q;

    // Elapsed-cycle counter; subtract one interval per completed refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (refb_done) begin
            elapsed_q <= elapsed_q - REFI_W + CW'(1);
        end else if (elapsed_q != SAT_W) begin
            elapsed_q <= elapsed_q + CW'(1);
        end
    end

    // Due once a whole interval is owed.
    always_comb due = (elapsed_q >= REFI_W);

    // Owed refresh stays owed until a refresh completes.
    assert_due_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !refb_done) |=> due);

    // Completion never arrives for a refresh that was not due.
    assert_done_when_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
        refb_done |-> due);

endmodule

// File: rtl/brs_bank_ptr.sv
// Round-robin bank pointer with block-line decoder.
// Holds the index of the next bank to refresh and advances modulo NUM_BANKS
// when told. Drives one block line per bank, high for the pointed bank while
// block_en is set.
module brs_bank_ptr #(
    parameter int NUM_BANKS = 8,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    input  logic                 block_en,
    output logic [BW-1:0]        ptr,
    output logic [NUM_BANKS-1:0] bank_block
);
    localparam logic [BW-1:0] LAST = BW'(NUM_BANKS - 1);

    logic [BW-1:0] ptr_q;

    // Pointer register; wraps after the last bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + BW'(1);
        end
    end

    always_comb ptr = ptr_q;

    // One decoder leg per bank.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_blk
        assign bank_block[g] = block_en && (ptr_q == BW'(g));
    end

    // Pointer moves only on an advance.
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));

    // Pointer never leaves the valid bank range.
    assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);

endmodule

// File: rtl/brs_seq_fsm.sv
// Refresh command sequencer.
// In IDLE it waits for the due flag, then chooses precharge or per-bank
// refresh from the target bank's open flag. A command fires when it is
// pending, legal and acknowledged. A fired precharge leads to the refresh of
// the same bank; a fired refresh returns to IDLE and reports completion.
module brs_seq_fsm
    import brs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     due,
    input  logic     tgt_open,
    input  logic     cmd_legal,
    input  logic     cmd_ack,
    output logic     pending,
    output brs_cmd_e cmd_kind,
    output logic     refb_done
);
    brs_state_e state_q, state_d;
    logic       fire;

    // A command is taken only when shown, legal and acknowledged.
    always_comb fire = pending && cmd_legal && cmd_ack;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (due) state_d = tgt_open ? ST_WAIT_PRE : ST_WAIT_REFB;
            ST_WAIT_PRE:  if (fire) state_d = ST_WAIT_REFB;
            ST_WAIT_REFB: if (fire) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from state.
    always_comb begin
        pending   = (state_q != ST_IDLE);
        refb_done = (state_q == ST_WAIT_REFB) && fire;
        unique case (state_q)
            ST_WAIT_PRE:  cmd_kind = CMD_PRE;
            ST_WAIT_REFB: cmd_kind = CMD_REFB;
            default:      cmd_kind = CMD_NOP;
        endcase
    end

    // Closed bank goes straight to refresh.
    assert_closed_refb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && due && !tgt_open) |=> state_q == ST_WAIT_REFB);

    // Precharge is always followed by the refresh.
    assert_pre_then_refb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_PRE && cmd_legal && cmd_ack) |=> state_q == ST_WAIT_REFB);

    // Without a legal acknowledge, a pending command stays put.
    assert_wait_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(cmd_legal && cmd_ack)) |=> $stable(state_q));

endmodule

// File: rtl/bank_refresh_seq.sv
// Per-bank refresh sequencer, top level.
// Ties the due timer, the round-robin bank pointer and the command sequencer.
// Assumes bank_open reflects the bank state at the due point and that the
// request machine of a blocked bank opens no new row.
module bank_refresh_seq
    import brs_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int REFI_CYCLES = 3900,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 cmd_legal,
    input  logic                 cmd_ack,
    output logic                 cmd_req,
    output logic [1:0]           cmd_type,
    output logic [BW-1:0]        cmd_bank,
    output logic [NUM_BANKS-1:0] bank_block
);
    logic          due;
    logic          refb_done;
    logic          pending;
    logic          tgt_open;
    logic [BW-1:0] ptr;
    brs_cmd_e      cmd_kind;

    brs_due_timer #(.REFI_CYCLES(REFI_CYCLES)) u_due (
        .clk       (clk),
        .rst_n     (rst_n),
        .refb_done (refb_done),
        .due       (due)
    );

    brs_bank_ptr #(.NUM_BANKS(NUM_BANKS)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (refb_done),
        .block_en   (pending),
        .ptr        (ptr),
        .bank_block (bank_block)
    );

    // Open flag of the bank next in rotation.
    always_comb tgt_open = bank_open[ptr];

    brs_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .due       (due),
        .tgt_open  (tgt_open),
        .cmd_legal (cmd_legal),
        .cmd_ack   (cmd_ack),
        .pending   (pending),
        .cmd_kind  (cmd_kind),
        .refb_done (refb_done)
    );

    // Command bus outputs; no bank attached while idle.
    always_comb begin
        cmd_req  = pending && cmd_legal;
        cmd_type = cmd_kind;
        cmd_bank = pending ? ptr : '0;
    end

    // Idle bus is quiet.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_block == '0) |-> (cmd_type == CMD_NOP && !cmd_req && cmd_bank == '0));

    // At most one bank is held off at a time.
    assert_block_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_block));

    // A held-off bank is the one the command addresses.
    assert_block_matches_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_block != '0) |-> bank_block[cmd_bank]);

endmodule

// File: tb/bank_refresh_seq_bench.sv
module bank_refresh_seq_bench;
    import brs_pkg::*;

    localparam int NB   = 4;
    localparam int REFI = 40;
    localparam int BW   = $clog2(NB);
    localparam int NV   = 8;

    // Stimulus / expectation table: open flag, legal delay, expected bank.
    localparam bit VEC_OPEN [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int VEC_WAIT [NV] = '{0, 2, 3, 0, 45, 0, 1, 0};
    localparam int VEC_BANK [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NB-1:0] bank_open;
    logic          cmd_legal;
    logic          cmd_ack;
    logic          cmd_req;
    logic [1:0]    cmd_type;
    logic [BW-1:0] cmd_bank;
    logic [NB-1:0] bank_block;

    int n_tests = 0;
    int n_fail  = 0;
    int edge_n;
    int last_done;
    int n_done;

    always #2 clk = ~clk;

    bank_refresh_seq #(.NUM_BANKS(NB), .REFI_CYCLES(REFI)) u_bank_refresh_seq (
        .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .cmd_legal(cmd_legal),
        .cmd_ack(cmd_ack), .cmd_req(cmd_req), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .bank_block(bank_block)
    );

    // Edges seen with reset released.
    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Wait for a block line to rise, then check its timing.
    task automatic wait_rise(input int exp_edge, input string req);
        int guard = 0;
        while (bank_block == '0 && guard < 4 * REFI) begin
            @(negedge clk);
            guard++;
        end
        check(edge_n == exp_edge, req, edge_n, exp_edge);
    endtask

    // Hold legal low for wait_n cycles with stray acks, then issue.
    task automatic issue(input int wait_n, input brs_cmd_e exp_kind);
        for (int w = 0; w < wait_n; w++) begin
            cmd_legal = 1'b0;
            cmd_ack   = 1'b1;
            #1;
            check(cmd_req == 1'b0, "R5 req while illegal", int'(cmd_req), 0);
            @(negedge clk);
            check(cmd_type == exp_kind, "R5 stray ack ignored", int'(cmd_type), int'(exp_kind));
        end
        cmd_legal = 1'b1;
        cmd_ack   = 1'b1;
        #1;
        check(cmd_req == 1'b1, "R5 req when legal", int'(cmd_req), 1);
        @(negedge clk);
        cmd_legal = 1'b0;
        cmd_ack   = 1'b0;
    endtask

    // One full refresh of a bank, with all checks.
    task automatic one_refresh(input bit open, input int wait_n, input int bank);
        int nominal = (n_done + 1) * REFI;
        int exp_edge = ((nominal > last_done) ? nominal : last_done) + 1;
        string tag = (n_done == 0) ? "R2 first due" :
                     (last_done >= nominal) ? "R9 backlog start" : "R7 due anchor";
        bank_open = open ? (NB'(1) << bank) : '0;
        wait_rise(exp_edge, tag);
        check(bank_block == (NB'(1) << bank), "R8 block line", int'(bank_block), 1 << bank);
        check(int'(cmd_bank) == bank, "R6 rotation", int'(cmd_bank), bank);
        if (open) begin
            check(cmd_type == CMD_PRE, "R4 precharge first", int'(cmd_type), int'(CMD_PRE));
            issue(wait_n, CMD_PRE);
            check(cmd_type == CMD_REFB, "R4 refresh after precharge", int'(cmd_type), int'(CMD_REFB));
            check(int'(cmd_bank) == bank, "R4 same bank", int'(cmd_bank), bank);
            bank_open = '0;
        end else begin
            check(cmd_type == CMD_REFB, "R3 direct refresh", int'(cmd_type), int'(CMD_REFB));
        end
        issue(wait_n, CMD_REFB);
        last_done = edge_n;
        n_done++;
        check(bank_block == '0, "R8 release", int'(bank_block), 0);
        check(cmd_type == CMD_NOP && cmd_bank == '0, "R1 idle nop", int'(cmd_type), 0);
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bank_open = '0; cmd_legal = 1'b0; cmd_ack = 1'b0;
        repeat (3) @(negedge clk);
        check(bank_block == '0 && cmd_req == 1'b0, "R1 reset outputs", int'(bank_block), 0);
        check(cmd_type == CMD_NOP && cmd_bank == '0, "R1 reset nop", int'(cmd_type), 0);
        rst_n = 1'b1;
        last_done = 0;
        n_done = 0;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            one_refresh(VEC_OPEN[i], VEC_WAIT[i], VEC_BANK[i]);
        end

        // Reset while a refresh is pending.
        bank_open = NB'(1);
        wait_rise((n_done + 1) * REFI + 1, "R7 due anchor");
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(bank_block == '0 && cmd_req == 1'b0, "R1 reset mid refresh", int'(bank_block), 0);
        check(cmd_type == CMD_NOP, "R1 reset mid refresh type", int'(cmd_type), 0);
        rst_n = 1'b1;
        last_done = 0;
        n_done = 0;
        one_refresh(1'b0, 0, 0);  // R6: pointer back at bank 0 after reset

        // Stray acks while idle must not advance anything.
        for (int s = 0; s < 10; s++) begin
            cmd_legal = 1'b1;
            cmd_ack   = 1'b1;
            #1;
            check(cmd_req == 1'b0, "R5 idle ack ignored", int'(cmd_req), 0);
            @(negedge clk);
        end
        cmd_legal = 1'b0;
        cmd_ack   = 1'b0;
        one_refresh(1'b1, 1, 1);  // R6: next bank is still bank 1

        finish_run();
    end

endmodule